// File: doc/BRIEF.md
# I2C Peripheral Control Register

This block holds the control byte of an I2C master/slave peripheral and applies the hardware rules that set and clear its bits. Software writes the byte through a simple write strobe and data bus and reads it back at any time. The protocol engine supplies strobes and flags: start condition sent, stop condition sent, master mode, byte transfer finished, bus busy, the clock-stretch flags and a received-address qualifier. From the stored bits the block drives level request outputs to that engine, a hold-clock-low output and an interrupt request.

Turning the peripheral on takes two writes. The first write with the enable bit set only switches the peripheral on; the second loads the remaining bits. While the peripheral is off, every configuration bit except the stop/release bit is held at zero and every output is released. The stop/release bit keeps its value across a disable. In master mode it is cleared by hardware once the stop condition is out. In slave mode only software clears it.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the read value is 00h and all outputs are 0. Bits 7 and 6 always read 0, whatever value is written to them.
- R2: The bit positions are enable = bit 5, general-call enable = bit 4, start = bit 3, acknowledge enable = bit 2, stop/release = bit 1, interrupt enable = bit 0. A write takes effect at the next clock edge.
- R3: A write with bit 5 = 1 while the peripheral is disabled sets only the enable bit. The other written bits are discarded.
- R4: While enable = 0, bits 4, 3, 2 and 0 read 0. The stop bit is loaded by every write made while enabled, including the write that disables the peripheral. Writes made while disabled never change the stop bit.
- R5: startSent clears the start bit at the next edge. If a write in the same cycle sets the start bit, the clear wins.
- R6: In master mode, stopSent clears the stop bit at the next edge, and the clear wins over a write in the same cycle.
- R7: In slave mode the stop bit is never cleared by hardware. releaseReq = enable AND stop AND slave mode AND byteDone.
- R8: gcAccept is 1 only when addrValid = 1, enable = 1, general-call enable = 1 and rxAddr = 00h. Address 01h is never accepted.
- R9: sclHold = enable AND (byteDone OR any bit of stretchFlags).
- R10: irq = interrupt enable AND (startSent OR stopSent), combinationally.
- R11: startReq = enable AND start AND (masterMode OR NOT busBusy). stopReq = enable AND stop AND masterMode.
- R12: While enable = 0, startReq, stopReq, releaseReq, sclHold, gcAccept and irq are all 0, even when the stop bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read-back value of the register |
| startSent | input | 1 | Strobe: start condition sent |
| stopSent | input | 1 | Strobe: stop condition sent |
| masterMode | input | 1 | 1 = master mode, 0 = slave mode |
| byteDone | input | 1 | Byte transfer finished flag |
| busBusy | input | 1 | Bus busy flag |
| stretchFlags | input | STRETCH_N | 10-bit header, start bit, address matched and post-address event flags |
| addrValid | input | 1 | Received address is valid |
| rxAddr | input | ADDR_W | Received address byte |
| enOut | output | 1 | Enable bit |
| gcEnOut | output | 1 | General-call enable bit |
| ackEnOut | output | 1 | Acknowledge enable bit |
| intEnOut | output | 1 | Interrupt enable bit |
| startReq | output | 1 | Start / repeated-start request |
| stopReq | output | 1 | Master stop request |
| releaseReq | output | 1 | Slave release-lines request |
| gcAccept | output | 1 | General-call address accepted |
| sclHold | output | 1 | Hold clock line low |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults: DATA_W = 8, ADDR_W = 8 and STRETCH_N = 4. With an 8-bit data width, writes can place ones in the two reserved bits, so the bench checks that they are dropped. With 8-bit addresses it can tell 00h apart from 01h for the general-call check. With four stretch flags, each flag can be raised on its own, both while enabled and while disabled. The vector table also covers a write and a hardware clear landing in the same cycle, so it shows which one wins.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int BIT_PE    = 5;
  localparam int BIT_GCEN  = 4;
  localparam int BIT_START = 3;
  localparam int BIT_ACK   = 2;
  localparam int BIT_STOP  = 1;
  localparam int BIT_ITE   = 0;
  localparam int FIELD_N   = 6;

  typedef struct packed {
    logic peLoad;
    logic peVal;
    logic cfgLoad;
    logic cfgClear;
    logic stopLoad;
    logic startClr;
    logic stopClr;
  } ctlStrobes_t;
endpackage

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
  import i2c_ctl_pkg::*;
(
  input  logic        wrEn,
  input  logic        wrPe,
  input  logic        peQ,
  input  logic        startSent,
  input  logic        stopSent,
  input  logic        masterMode,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.peLoad   = wrEn;
    strobes.peVal    = wrPe;
    // a first enabling write while off only sets PE (R3)
    strobes.cfgLoad  = wrEn & peQ & wrPe;
    strobes.cfgClear = wrEn & ~wrPe;
    // STOP is loaded only by writes made while enabled (R4)
    strobes.stopLoad = wrEn & peQ;
    strobes.startClr = startSent;
    strobes.stopClr  = stopSent & masterMode;
  end
endmodule

// File: rtl/i2c_ctl_dp.sv
module i2c_ctl_dp
  import i2c_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  output logic              peQ,
  output logic              gcenQ,
  output logic              startQ,
  output logic              ackQ,
  output logic              stopQ,
  output logic              iteQ
);
  logic [FIELD_N-1:0] fieldVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peQ <= 1'b0; gcenQ <= 1'b0; startQ <= 1'b0;
      ackQ <= 1'b0; stopQ <= 1'b0; iteQ <= 1'b0;
    end else begin
      if (strobes.peLoad) peQ <= strobes.peVal;
      if (strobes.cfgClear) begin
        gcenQ <= 1'b0; ackQ <= 1'b0; iteQ <= 1'b0;
      end else if (strobes.cfgLoad) begin
        gcenQ <= wrData[BIT_GCEN];
        ackQ  <= wrData[BIT_ACK];
        iteQ  <= wrData[BIT_ITE];
      end
      if (strobes.startClr || strobes.cfgClear) startQ <= 1'b0;
      else if (strobes.cfgLoad) startQ <= wrData[BIT_START];
      if (strobes.stopClr) stopQ <= 1'b0;
      else if (strobes.stopLoad) stopQ <= wrData[BIT_STOP];
    end
  end

  always_comb begin
    fieldVec            = '0;
    fieldVec[BIT_PE]    = peQ;
    fieldVec[BIT_GCEN]  = gcenQ;
    fieldVec[BIT_START] = startQ;
    fieldVec[BIT_ACK]   = ackQ;
    fieldVec[BIT_STOP]  = stopQ;
    fieldVec[BIT_ITE]   = iteQ;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i < FIELD_N) begin : g_fld
      assign rdData[i] = fieldVec[i];
    end else begin : g_rsvd
      assign rdData[i] = 1'b0;
    end
  end

  // R1: reserved bits written as ones never show up
  a_r1_rsvd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (|wrData[DATA_W-1:FIELD_N])) |=> (rdData[DATA_W-1:FIELD_N] == '0));
  // R3: first enabling write leaves the config bits clear
  a_r3_first_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !peQ && wrData[BIT_PE]) |=> (peQ && !gcenQ && !startQ && !ackQ && !iteQ));
  // R4: disabled means config bits are zero
  a_r4_off_zero: assert property (@(posedge clk) disable iff (!rstN)
    !peQ |-> !(gcenQ || startQ || ackQ || iteQ));
  // R5: start-sent clears START
  a_r5_start_clr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startClr |=> !startQ);
  // R6: master stop-sent clears STOP
  a_r6_stop_clr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stopClr |=> !stopQ);
  // R7: without a write or a master clear, STOP holds
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !strobes.stopClr && !strobes.stopLoad) |=> stopQ);
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int STRETCH_N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 startSent,
  input  logic                 stopSent,
  input  logic                 masterMode,
  input  logic                 byteDone,
  input  logic                 busBusy,
  input  logic [STRETCH_N-1:0] stretchFlags,
  input  logic                 addrValid,
  input  logic [ADDR_W-1:0]    rxAddr,
  output logic                 enOut,
  output logic                 gcEnOut,
  output logic                 ackEnOut,
  output logic                 intEnOut,
  output logic                 startReq,
  output logic                 stopReq,
  output logic                 releaseReq,
  output logic                 gcAccept,
  output logic                 sclHold,
  output logic                 irq
);
  ctlStrobes_t strobes;
  logic peQ, gcenQ, startQ, ackQ, stopQ, iteQ;

  i2c_ctl_seq u_seq (
    .wrEn       (wrEn),
    .wrPe       (wrData[BIT_PE]),
    .peQ        (peQ),
    .startSent  (startSent),
    .stopSent   (stopSent),
    .masterMode (masterMode),
    .strobes    (strobes)
  );

  i2c_ctl_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .rdData  (rdData),
    .peQ     (peQ),
    .gcenQ   (gcenQ),
    .startQ  (startQ),
    .ackQ    (ackQ),
    .stopQ   (stopQ),
    .iteQ    (iteQ)
  );

  assign enOut      = peQ;
  assign gcEnOut    = gcenQ;
  assign ackEnOut   = ackQ;
  assign intEnOut   = iteQ;
  assign startReq   = peQ & startQ & (masterMode | ~busBusy);
  assign stopReq    = peQ & stopQ & masterMode;
  assign releaseReq = peQ & stopQ & ~masterMode & byteDone;
  assign gcAccept   = addrValid & peQ & gcenQ & (rxAddr == '0);
  assign sclHold    = peQ & (byteDone | (|stretchFlags));
  assign irq        = iteQ & (startSent | stopSent);

  // R12: every output released while disabled
  a_r12_released: assert property (@(posedge clk) disable iff (!rstN)
    !enOut |-> !(startReq || stopReq || releaseReq || gcAccept || sclHold || irq));
  // R8: a nonzero address is never accepted as a general call
  a_r8_gc_zero_only: assert property (@(posedge clk) disable iff (!rstN)
    gcAccept |-> (rxAddr == '0 && gcEnOut));
  // R7: release is a slave-mode request only
  a_r7_release_slave: assert property (@(posedge clk) disable iff (!rstN)
    releaseReq |-> (!masterMode && !stopReq));
endmodule

// File: tb/sim_i2c_ctl_reg.sv
module sim_i2c_ctl_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic startSent = 1'b0, stopSent = 1'b0, masterMode = 1'b0;
  logic byteDone = 1'b0, busBusy = 1'b0, addrValid = 1'b0;
  logic [3:0] stretchFlags = '0;
  logic [7:0] rxAddr = '0;
  logic enOut, gcEnOut, ackEnOut, intEnOut, startReq, stopReq;
  logic releaseReq, gcAccept, sclHold, irq;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_ctl_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .startSent(startSent), .stopSent(stopSent), .masterMode(masterMode),
    .byteDone(byteDone), .busBusy(busBusy), .stretchFlags(stretchFlags),
    .addrValid(addrValid), .rxAddr(rxAddr), .enOut(enOut), .gcEnOut(gcEnOut),
    .ackEnOut(ackEnOut), .intEnOut(intEnOut), .startReq(startReq),
    .stopReq(stopReq), .releaseReq(releaseReq), .gcAccept(gcAccept),
    .sclHold(sclHold), .irq(irq)
  );

  // {wr, data[7:0], startSent, stopSent, masterMode, expected rdData[7:0]}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h20},  // R3 first write sets PE only
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h3F},  // R1 R2 reserved bits dropped
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h37},  // R5 start cleared
    {1'b1, 8'h2E, 1'b0, 1'b1, 1'b1, 8'h2C},  // R6 master stop clear beats write
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 8'h22},  // R2 load stop
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h22},  // R7 slave stop not cleared
    {1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 8'h02},  // R4 disable, stop loaded
    {1'b1, 8'h3D, 1'b0, 1'b0, 1'b0, 8'h22},  // R4 stop kept on enabling write
    {1'b1, 8'h29, 1'b1, 1'b0, 1'b0, 8'h21},  // R5 start clear beats write
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}   // R4 disable clears all
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset read", rdData, 8'h00);
    check("R1 reset outputs", {enOut, gcEnOut, ackEnOut, intEnOut, startReq, stopReq,
          releaseReq, gcAccept}, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VEC[i][19]; wrData = VEC[i][18:11];
      startSent = VEC[i][10]; stopSent = VEC[i][9]; masterMode = VEC[i][8];
      @(posedge clk); #1;
      wrEn = 1'b0; startSent = 1'b0; stopSent = 1'b0;
      check($sformatf("R2 vector %0d", i), rdData, VEC[i][7:0]);
    end

    // enable fully: PE, GCEN, ACK, ITE
    masterMode = 1'b0;
    doWrite(8'h20);
    doWrite(8'h35);
    check("R2 enabled read", rdData, 8'h35);
    // R8 general call
    @(negedge clk); addrValid = 1'b1; rxAddr = 8'h00; #1;
    check("R8 gc 00h", {7'd0, gcAccept}, 8'h01);
    rxAddr = 8'h01; #1;
    check("R8 gc 01h", {7'd0, gcAccept}, 8'h00);
    addrValid = 1'b0; rxAddr = 8'h00; #1;
    check("R8 gc not valid", {7'd0, gcAccept}, 8'h00);
    // R10 irq
    startSent = 1'b1; #1;
    check("R10 irq start", {7'd0, irq}, 8'h01);
    startSent = 1'b0; stopSent = 1'b1; #1;
    check("R10 irq stop", {7'd0, irq}, 8'h01);
    stopSent = 1'b0; #1;
    check("R10 irq idle", {7'd0, irq}, 8'h00);
    // R9 clock hold
    for (int f = 0; f < 4; f++) begin
      stretchFlags = 4'b1 << f; #1;
      check("R9 hold flag", {7'd0, sclHold}, 8'h01);
    end
    stretchFlags = '0; byteDone = 1'b1; #1;
    check("R9 hold byteDone", {7'd0, sclHold}, 8'h01);
    byteDone = 1'b0; #1;
    check("R9 hold idle", {7'd0, sclHold}, 8'h00);
    // R11 start request, slave, bus busy then free (PE START ITE)
    doWrite(8'h29);
    busBusy = 1'b1; #1;
    check("R11 slave busy", {7'd0, startReq}, 8'h00);
    busBusy = 1'b0; #1;
    check("R11 slave free", {7'd0, startReq}, 8'h01);
    masterMode = 1'b1; busBusy = 1'b1; #1;
    check("R11 master repeated", {7'd0, startReq}, 8'h01);
    // R7 release in slave mode; R11 stop request in master mode
    doWrite(8'h22);
    #1;
    check("R11 master stopReq", {7'd0, stopReq}, 8'h01);
    masterMode = 1'b0; byteDone = 1'b0; #1;
    check("R7 release before btf", {7'd0, releaseReq}, 8'h00);
    byteDone = 1'b1; #1;
    check("R7 release on btf", {7'd0, releaseReq}, 8'h01);
    byteDone = 1'b0;
    // R12 disabled with STOP kept: outputs released
    doWrite(8'h02);
    check("R4 stop kept off", rdData, 8'h02);
    masterMode = 1'b1; byteDone = 1'b1; stretchFlags = 4'hF; addrValid = 1'b1;
    startSent = 1'b1; #1;
    check("R12 released", {2'd0, stopReq, releaseReq, sclHold, gcAccept, irq, startReq},
          8'h00);
    masterMode = 1'b0; #1;
    check("R12 released slave", {7'd0, releaseReq}, 8'h00);
    @(negedge clk);
    byteDone = 1'b0; stretchFlags = '0; addrValid = 1'b0; startSent = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule